// File: doc/BRIEF.md
# Operand Bypass Select Unit

This block sits in front of the ALU of a five-stage in-order pipeline. For each source operand of the instruction now in the execute stage, it compares the register number against the destinations of older instructions further down the pipe. It then picks the youngest value that is still in flight and drives it into the ALU operand. The candidate sources are:

- the register file read,
- the ALU result held in the EX/MEM latch,
- the writeback value held in the MEM/WB latch, which carries load data when the instruction is a load,
- optionally, the value that left writeback one cycle earlier.

The last source exists only when the register file reads before it writes, for example one built from flip-flops. In that case an instruction three slots behind its producer would otherwise read a stale entry. The parameter `RF_WRITE_FIRST` removes this path when the register file writes in the first half-cycle. Stalls for a load followed directly by a consumer are generated elsewhere.

The unit reports a 2-bit select per operand next to the muxed operand value. Every decision uses only the current latch contents, plus a one-entry record of the last writeback.

Top module: `fwd_unit`

## Requirements
- R1: When the EX/MEM entry has its write flag set, is not a load, names a nonzero destination, and that destination equals an operand's source, the operand select is 2'b10 and the operand value is the EX/MEM ALU result.
- R2: When R1 does not apply, and the MEM/WB entry has its write flag set with a nonzero destination equal to the source, the select is 2'b01. The value is the load data if the MEM/WB memory-to-register flag is set, and the MEM/WB ALU result otherwise.
- R3: An EX/MEM entry with its memory-to-register flag set never gives select 2'b10; the operand falls through to the older sources.
- R4: When EX/MEM and MEM/WB both match the same source, EX/MEM wins (select 2'b10).
- R5: A source of register 0 always gets select 2'b00 and the register file value, whatever the destinations hold.
- R6: A stage whose write flag is clear never forwards, even when its destination matches.
- R7: With `RF_WRITE_FIRST` = 0, the select is 2'b11 when three conditions hold: no younger stage matches, and in the previous cycle the MEM/WB entry had its write flag set with a nonzero destination equal to the source. The value is then the writeback value of that previous cycle.
- R8: With `RF_WRITE_FIRST` = 1, the select is never 2'b11; the case in R7 gives select 2'b00 and the register file value.
- R9: Reset clears the record of the last writeback, so in the first cycle after reset the select is never 2'b11.
- R10: Whenever the select is 2'b00, the operand value equals that operand's register file input.
- R11: Each operand is decided on its own; the two operands may take different sources in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_reg | input | NUM_SRC x AW | Source register numbers of the execute-stage instruction |
| rf_val | input | NUM_SRC x DW | Register file read values for each operand |
| exm_rd | input | AW | EX/MEM destination register |
| exm_wr | input | 1 | EX/MEM register-write flag |
| exm_ld | input | 1 | EX/MEM memory-to-register flag |
| exm_alu | input | DW | EX/MEM ALU result |
| mwb_rd | input | AW | MEM/WB destination register |
| mwb_wr | input | 1 | MEM/WB register-write flag |
| mwb_ld | input | 1 | MEM/WB memory-to-register flag |
| mwb_alu | input | DW | MEM/WB ALU result |
| mwb_load | input | DW | MEM/WB load data |
| op_sel | output | NUM_SRC x 2 | Per-operand select: 00 register file, 01 MEM/WB, 10 EX/MEM, 11 retired writeback |
| op_val | output | NUM_SRC x DW | Per-operand value driven into the ALU |

## Verification
The only internal state is the one-entry record of the last writeback. If it is wrong, select 2'b11 appears or fails to appear in the cycle right after a matching MEM/WB entry, or the operand carries a value other than the previous cycle's writeback data. A fault in the record therefore shows on the ports one clock after the write it concerns. Every other mistake is combinational and appears in the same cycle the latch contents are presented. The bench drives random destinations over a small register range so that every priority overlap occurs often. It runs two instances, one per register-file ordering.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MWB = 2'b01,
    SRC_EXM = 2'b10,
    SRC_RET = 2'b11
  } fwd_src_e;
endpackage

// File: rtl/fwd_cmp.sv
// Match detector: one source specifier against one producer destination.
module fwd_cmp #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wr_en,
  input  logic          allow,
  output logic          hit
);
  logic dst_nonzero;
  assign dst_nonzero = |dst;
  assign hit = allow & wr_en & dst_nonzero & (dst == src);
endmodule

// File: rtl/fwd_pick.sv
// Priority: youngest producer first.
module fwd_pick
  import fwd_pkg::*;
(
  input  logic     hit_exm,
  input  logic     hit_mwb,
  input  logic     hit_ret,
  output fwd_src_e sel
);
  always_comb begin
    if (hit_exm)      sel = SRC_EXM;
    else if (hit_mwb) sel = SRC_MWB;
    else if (hit_ret) sel = SRC_RET;
    else              sel = SRC_RF;
  end
endmodule

// File: rtl/fwd_ret_stage.sv
// One-entry record of the value that left writeback last cycle.
module fwd_ret_stage #(
  parameter int AW   = 5,
  parameter int DW   = 32,
  parameter bit KEEP = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] in_rd,
  input  logic          in_wr,
  input  logic [DW-1:0] in_val,
  output logic [AW-1:0] out_rd,
  output logic          out_wr,
  output logic [DW-1:0] out_val
);
  generate
    if (KEEP) begin : g_keep
      always_ff @(posedge clk) begin
        if (rst) begin
          out_wr  <= 1'b0;
          out_rd  <= '0;
          out_val <= '0;
        end else begin
          out_wr  <= in_wr;
          out_rd  <= in_rd;
          out_val <= in_val;
        end
      end
    end else begin : g_none
      assign out_wr  = 1'b0;
      assign out_rd  = '0;
      assign out_val = '0;
    end
  endgenerate
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
  import fwd_pkg::*;
#(
  parameter int DW = 32
) (
  input  fwd_src_e      sel,
  input  logic [DW-1:0] rf,
  input  logic [DW-1:0] exm,
  input  logic [DW-1:0] mwb,
  input  logic [DW-1:0] ret,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (sel)
      SRC_EXM: y = exm;
      SRC_MWB: y = mwb;
      SRC_RET: y = ret;
      default: y = rf;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int AW             = 5,
  parameter int DW             = 32,
  parameter int NUM_SRC        = 2,
  parameter bit RF_WRITE_FIRST = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SRC-1:0][AW-1:0]    src_reg,
  input  logic [NUM_SRC-1:0][DW-1:0]    rf_val,
  input  logic [AW-1:0]                 exm_rd,
  input  logic                          exm_wr,
  input  logic                          exm_ld,
  input  logic [DW-1:0]                 exm_alu,
  input  logic [AW-1:0]                 mwb_rd,
  input  logic                          mwb_wr,
  input  logic                          mwb_ld,
  input  logic [DW-1:0]                 mwb_alu,
  input  logic [DW-1:0]                 mwb_load,
  output logic [NUM_SRC-1:0][1:0]       op_sel,
  output logic [NUM_SRC-1:0][DW-1:0]    op_val
);
  localparam bit KEEP_RET = !RF_WRITE_FIRST;

  logic [DW-1:0] wb_val;
  logic [AW-1:0] ret_rd;
  logic          ret_wr;
  logic [DW-1:0] ret_val;
  logic          exm_alu_ok;

  // Load data reaches the bypass only through MEM/WB.
  assign wb_val     = mwb_ld ? mwb_load : mwb_alu;
  assign exm_alu_ok = ~exm_ld;

  fwd_ret_stage #(.AW(AW), .DW(DW), .KEEP(KEEP_RET)) u_ret (
    .clk(clk), .rst(rst),
    .in_rd(mwb_rd), .in_wr(mwb_wr), .in_val(wb_val),
    .out_rd(ret_rd), .out_wr(ret_wr), .out_val(ret_val)
  );

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
      logic     hit_exm, hit_mwb, hit_ret;
      fwd_src_e sel;

      fwd_cmp #(.AW(AW)) u_cmp_exm (
        .src(src_reg[g]), .dst(exm_rd), .wr_en(exm_wr),
        .allow(exm_alu_ok), .hit(hit_exm)
      );
      fwd_cmp #(.AW(AW)) u_cmp_mwb (
        .src(src_reg[g]), .dst(mwb_rd), .wr_en(mwb_wr),
        .allow(1'b1), .hit(hit_mwb)
      );
      fwd_cmp #(.AW(AW)) u_cmp_ret (
        .src(src_reg[g]), .dst(ret_rd), .wr_en(ret_wr),
        .allow(KEEP_RET), .hit(hit_ret)
      );
      fwd_pick u_pick (
        .hit_exm(hit_exm), .hit_mwb(hit_mwb), .hit_ret(hit_ret), .sel(sel)
      );
      fwd_opmux #(.DW(DW)) u_mux (
        .sel(sel), .rf(rf_val[g]), .exm(exm_alu), .mwb(wb_val),
        .ret(ret_val), .y(op_val[g])
      );
      assign op_sel[g] = sel;
    end
  endgenerate
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int AW             = 5,
  parameter int DW             = 32,
  parameter int NUM_SRC        = 2,
  parameter bit RF_WRITE_FIRST = 1'b0
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_SRC-1:0][AW-1:0] src_reg,
  input logic [NUM_SRC-1:0][DW-1:0] rf_val,
  input logic [AW-1:0]              exm_rd,
  input logic                       exm_wr,
  input logic                       exm_ld,
  input logic [DW-1:0]              exm_alu,
  input logic [AW-1:0]              mwb_rd,
  input logic                       mwb_wr,
  input logic                       mwb_ld,
  input logic [DW-1:0]              mwb_alu,
  input logic [DW-1:0]              mwb_load,
  input logic [NUM_SRC-1:0][1:0]    op_sel,
  input logic [NUM_SRC-1:0][DW-1:0] op_val
);
  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_a
      AST_EXM_WINS: assert property (@(posedge clk) disable iff (rst)
        (exm_wr && !exm_ld && exm_rd != '0 && exm_rd == src_reg[g])
          |-> (op_sel[g] == 2'b10 && op_val[g] == exm_alu)); // R1
      AST_LOAD_NOT_EXM: assert property (@(posedge clk) disable iff (rst)
        exm_ld |-> op_sel[g] != 2'b10); // R3
      AST_MWB_VALUE: assert property (@(posedge clk) disable iff (rst)
        (op_sel[g] == 2'b01) |-> (mwb_wr && mwb_rd != '0 && mwb_rd == src_reg[g]
          && op_val[g] == (mwb_ld ? mwb_load : mwb_alu))); // R2
      AST_ZERO_SRC: assert property (@(posedge clk) disable iff (rst)
        (src_reg[g] == '0) |-> (op_sel[g] == 2'b00 && op_val[g] == rf_val[g])); // R5
      AST_RF_VALUE: assert property (@(posedge clk) disable iff (rst)
        (op_sel[g] == 2'b00) |-> op_val[g] == rf_val[g]); // R10
      AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> op_sel[g] != 2'b11); // R9
      if (RF_WRITE_FIRST) begin : g_wf
        AST_NO_RETIRED: assert property (@(posedge clk) disable iff (rst)
          op_sel[g] != 2'b11); // R8
      end else begin : g_rbw
        AST_RETIRED_VALUE: assert property (@(posedge clk) disable iff (rst)
          (op_sel[g] == 2'b11) |-> ($past(mwb_wr) && $past(mwb_rd) == src_reg[g]
            && op_val[g] == $past(mwb_ld ? mwb_load : mwb_alu))); // R7
      end
    end
  endgenerate
endmodule

bind fwd_unit fwd_unit_chk #(
  .AW(AW), .DW(DW), .NUM_SRC(NUM_SRC), .RF_WRITE_FIRST(RF_WRITE_FIRST)
) u_chk (
  .clk(clk), .rst(rst), .src_reg(src_reg), .rf_val(rf_val),
  .exm_rd(exm_rd), .exm_wr(exm_wr), .exm_ld(exm_ld), .exm_alu(exm_alu),
  .mwb_rd(mwb_rd), .mwb_wr(mwb_wr), .mwb_ld(mwb_ld), .mwb_alu(mwb_alu),
  .mwb_load(mwb_load), .op_sel(op_sel), .op_val(op_val)
);

// File: tb/fwd_unit_test.sv
`timescale 1ns/1ps
module fwd_unit_test;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0][AW-1:0] src_reg = '0;
  logic [NS-1:0][DW-1:0] rf_val = '0;
  logic [AW-1:0] exm_rd = '0, mwb_rd = '0;
  logic exm_wr = 0, exm_ld = 0, mwb_wr = 0, mwb_ld = 0;
  logic [DW-1:0] exm_alu = '0, mwb_alu = '0, mwb_load = '0;
  logic [NS-1:0][1:0]    sel_a, sel_b;
  logic [NS-1:0][DW-1:0] val_a, val_b;

  always #2.5 clk = ~clk;

  fwd_unit #(.AW(AW), .DW(DW), .NUM_SRC(NS), .RF_WRITE_FIRST(1'b0)) uut (
    .clk(clk), .rst(rst), .src_reg(src_reg), .rf_val(rf_val),
    .exm_rd(exm_rd), .exm_wr(exm_wr), .exm_ld(exm_ld), .exm_alu(exm_alu),
    .mwb_rd(mwb_rd), .mwb_wr(mwb_wr), .mwb_ld(mwb_ld), .mwb_alu(mwb_alu),
    .mwb_load(mwb_load), .op_sel(sel_a), .op_val(val_a));

  fwd_unit #(.AW(AW), .DW(DW), .NUM_SRC(NS), .RF_WRITE_FIRST(1'b1)) uut_wf (
    .clk(clk), .rst(rst), .src_reg(src_reg), .rf_val(rf_val),
    .exm_rd(exm_rd), .exm_wr(exm_wr), .exm_ld(exm_ld), .exm_alu(exm_alu),
    .mwb_rd(mwb_rd), .mwb_wr(mwb_wr), .mwb_ld(mwb_ld), .mwb_alu(mwb_alu),
    .mwb_load(mwb_load), .op_sel(sel_b), .op_val(val_b));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Reference record of the last writeback (behavioural queue of depth 1).
  logic [DW-1:0] ret_q[$];
  int            ret_rd_m = 0;
  bit            ret_wr_m = 0;

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_sel(int s, bit wf);
    if (s != 0 && exm_wr && !exm_ld && int'(exm_rd) == s) return 2'b10;
    if (s != 0 && mwb_wr && int'(mwb_rd) == s) return 2'b01;
    if (!wf && s != 0 && ret_wr_m && ret_rd_m == s) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] ref_val(logic [1:0] s, int g);
    case (s)
      2'b10: return exm_alu;
      2'b01: return mwb_ld ? mwb_load : mwb_alu;
      2'b11: return ret_q[0];
      default: return rf_val[g];
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] s);
    case (s)
      2'b10: return "R1";
      2'b01: return "R2";
      2'b11: return "R7";
      default: return "R10";
    endcase
  endfunction

  // Advance one clock: mirror the record update, then move to the falling edge.
  task automatic tick();
    @(posedge clk);
    ret_q.delete();
    if (rst) begin
      ret_wr_m = 0; ret_rd_m = 0; ret_q.push_back('0);
    end else begin
      ret_wr_m = mwb_wr; ret_rd_m = int'(mwb_rd);
      ret_q.push_back(mwb_ld ? mwb_load : mwb_alu);
    end
    @(negedge clk);
  endtask

  // Compare both instances against the model; empty tag picks one from the path.
  task automatic compare(string tag);
    #1;
    for (int g = 0; g < NS; g++) begin
      logic [1:0] ea, eb;
      ea = ref_sel(int'(src_reg[g]), 1'b0);
      eb = ref_sel(int'(src_reg[g]), 1'b1);
      check(tag == "" ? tag_of(ea) : tag, DW'(sel_a[g]), DW'(ea));
      check(tag == "" ? tag_of(ea) : tag, val_a[g], ref_val(ea, g));
      check(tag == "" ? (eb == 2'b00 ? "R8" : tag_of(eb)) : tag, DW'(sel_b[g]), DW'(eb));
      check(tag == "" ? (eb == 2'b00 ? "R8" : tag_of(eb)) : tag, val_b[g], ref_val(eb, g));
    end
  endtask

  task automatic idle();
    exm_wr = 0; exm_ld = 0; mwb_wr = 0; mwb_ld = 0;
    exm_rd = '0; mwb_rd = '0;
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    ret_q.push_back('0);
    rf_val[0] = 32'h1111_0000; rf_val[1] = 32'h2222_0000;
    exm_alu = 32'hEEEE_0001; mwb_alu = 32'hAAAA_0002; mwb_load = 32'hDDDD_0003;
    // R9: a matching writeback present during reset must not be recorded.
    mwb_rd = 5'd3; mwb_wr = 1; src_reg[0] = 5'd3; src_reg[1] = 5'd3;
    tick(); tick();
    rst = 0; idle();
    compare("R9");
    // R1: one-apart producer from EX/MEM.
    tick(); exm_rd = 5'd4; exm_wr = 1; src_reg[0] = 5'd4; src_reg[1] = 5'd9;
    compare("R1");
    // R4: both stages match, EX/MEM wins.
    tick(); idle(); exm_rd = 5'd6; exm_wr = 1; mwb_rd = 5'd6; mwb_wr = 1;
    src_reg[0] = 5'd6; src_reg[1] = 5'd6;
    compare("R4");
    // R3: load in EX/MEM falls through to MEM/WB load data (R2 path).
    tick(); idle(); exm_rd = 5'd7; exm_wr = 1; exm_ld = 1;
    mwb_rd = 5'd7; mwb_wr = 1; mwb_ld = 1; src_reg[0] = 5'd7; src_reg[1] = 5'd7;
    compare("R3");
    // R7: the MEM/WB load of the previous cycle is retired now.
    tick(); idle(); src_reg[0] = 5'd7; src_reg[1] = 5'd2;
    compare("R7");
    // R5: register 0 never forwards.
    tick(); idle(); exm_rd = 0; exm_wr = 1; mwb_rd = 0; mwb_wr = 1;
    src_reg[0] = 0; src_reg[1] = 0;
    compare("R5");
    // R6: write flags clear, destinations match.
    tick(); idle(); exm_rd = 5'd8; mwb_rd = 5'd8; src_reg[0] = 5'd8; src_reg[1] = 5'd8;
    compare("R6");
    tick(); compare("R6");
    // R11: operands take different sources in one cycle.
    tick(); idle(); exm_rd = 5'd10; exm_wr = 1; mwb_rd = 5'd11; mwb_wr = 1;
    src_reg[0] = 5'd10; src_reg[1] = 5'd11;
    compare("R11");
    // Random traffic over a narrow register range.
    for (int i = 0; i < 3000; i++) begin
      tick();
      for (int g = 0; g < NS; g++) begin
        src_reg[g] = AW'($urandom_range(0, 3));
        rf_val[g]  = $urandom;
      end
      exm_rd = AW'($urandom_range(0, 3)); exm_wr = 1'($urandom); exm_ld = 1'($urandom);
      mwb_rd = AW'($urandom_range(0, 3)); mwb_wr = 1'($urandom); mwb_ld = 1'($urandom);
      exm_alu = $urandom; mwb_alu = $urandom; mwb_load = $urandom;
      compare("");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule